// File: doc/BRIEF.md
# Four-Channel PCM Highway Slot Interface

This block carries 8-bit voice samples for four channels between per-channel sample registers and a serial PCM highway. The highway is made of a bit clock, a frame-sync pulse, one receive data line and one transmit data line. The transmit line has its own output-enable, so the transmit and receive lines can share a single wire. Each channel has its own transmit slot, its own receive slot and its own bit offset. The frame length is set in whole slots. A single mode bit chooses between one clock per data bit and two clocks per data bit.

Software-side logic writes configuration through a small write port. A written value first goes into a shadow copy. It becomes active only when the next frame sync is seen, so a frame already in progress always finishes under one consistent setting. The same rule applies to outgoing samples: a byte loaded for a channel is sent from the next frame onward. A received byte is presented with a one-cycle strobe.

Everything is clocked on the rising edge of the bit clock. Input data and frame sync are sampled on that edge. Output data changes just after it.

Top module: `pcm_tsi_quad`

## Requirements
- R1: After reset, and until the first frame sync is sampled, tx_oe is low and every rx_valid bit is low, whatever the configuration.
- R2: A frame-sync sampled high on a rising edge makes the following clock period bit position 0. Without further sync the position advances each data bit and wraps after (frame_slots_m1+1)*8 data bits.
- R3: An enabled channel with transmit slot s and offset o drives data positions o+8s to o+8s+7, most significant bit first. tx_oe is high exactly during positions some enabled channel owns.
- R4: An enabled channel with receive slot s and offset o shifts in rx_data during positions o+8s..o+8s+7, MSB first. In the clock period after the last bit is captured, rx_valid pulses for one cycle with the byte on rx_sample.
- R5: With the double-clock mode bit set, each data bit spans two clock periods. Transmit data is held for both periods. Receive data is captured at the edge that ends the second period.
- R6: A channel whose enable bit is 0 never drives tx_oe and never raises its rx_valid.
- R7: When several enabled channels own the same transmit position, the lowest-numbered one drives tx_data.
- R8: Configuration writes go to a shadow copy that becomes active only at the next sampled frame sync.
- R9: A pulse on tx_load[c] stores the byte for channel c. The byte transmitted in a frame is the one stored before that frame's sync.
- R10: Register map. cfg_addr[3:2] selects the field and cfg_addr[1:0] selects the channel. Field 0 is the transmit slot and field 1 is the receive slot. Field 2 is control: bit 7 is enable and bits 2:0 are the offset. For field 3, channel index 0 holds frame_slots_m1 and index 1 bit 0 holds the double-clock mode. Reset values are all zero, except frame_slots_m1 which resets to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync, one clock wide |
| rx_data | input | 1 | Serial receive data |
| tx_data | output | 1 | Serial transmit data, 0 when not enabled |
| tx_oe | output | 1 | Transmit output enable for a tristate driver |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address (field, channel) |
| cfg_wdata | input | 8 | Configuration write data |
| tx_load | input | 4 | Per-channel sample load strobe |
| tx_sample | input | 32 | Per-channel sample bytes, channel c at bits 8c+7:8c |
| rx_valid | output | 4 | Per-channel received-byte strobe |
| rx_sample | output | 32 | Per-channel received bytes, channel c at bits 8c+7:8c |

## Verification
The assertions assume that frame sync is a single-cycle pulse that arrives at most once per frame. They also assume that configuration and sample loads never share a cycle with a sync, so the shadow-to-active copy is unambiguous. The stimulus pulses sync only at the start of a frame task. It places every write and load on a negative edge that is strictly inside a frame. It picks receive slots whose last bit ends before the frame boundary, so no strobe spills into the next frame's first cycle.

// File: rtl/pcm_tsi_pkg.sv
package pcm_tsi_pkg;
  localparam int SLOT_W = 8;
  localparam int OFS_W  = 3;
  localparam int BIT_W  = 3;
  localparam int SMP_W  = 1 << BIT_W;
  localparam int POS_W  = SLOT_W + BIT_W;
  localparam int CNT_W  = POS_W + 1;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic             en;
    logic [OFS_W-1:0] ofs;
    slot_t            tx_slot;
    slot_t            rx_slot;
  } chan_cfg_t;

  // last clock index of a frame: (slots * 8 << dbl) - 1
  function automatic logic [CNT_W-1:0] frame_last(input slot_t slots_m1, input logic dbl);
    logic [CNT_W:0] nbits;
    nbits = {{(CNT_W-SLOT_W-BIT_W+1){1'b0}}, slots_m1, {BIT_W{1'b0}}} + (CNT_W+1)'(SMP_W);
    if (dbl) nbits = nbits << 1;
    return CNT_W'(nbits - (CNT_W+1)'(1));
  endfunction

  // data-bit position from the clock counter
  function automatic logic [POS_W-1:0] pos_of(input logic [CNT_W-1:0] cnt, input logic dbl);
    return dbl ? cnt[CNT_W-1:1] : cnt[POS_W-1:0];
  endfunction

  // capture edge: every edge in single mode, second edge of a bit in double mode
  function automatic logic last_phase(input logic [CNT_W-1:0] cnt, input logic dbl);
    return !dbl || cnt[0];
  endfunction

  function automatic logic slot_hit(input logic [POS_W-1:0] pos, input logic [OFS_W-1:0] ofs,
                                    input slot_t slot);
    logic [POS_W-1:0] rel;
    rel = pos - POS_W'(ofs);
    return (pos >= POS_W'(ofs)) && (rel[POS_W-1:BIT_W] == slot);
  endfunction

  function automatic logic [BIT_W-1:0] bit_of(input logic [POS_W-1:0] pos, input logic [OFS_W-1:0] ofs);
    logic [POS_W-1:0] rel;
    rel = pos - POS_W'(ofs);
    return rel[BIT_W-1:0];
  endfunction
endpackage

// File: rtl/pcm_tsi_cfg.sv
module pcm_tsi_cfg
  import pcm_tsi_pkg::*;
#(
  parameter int    NCH          = 4,
  parameter int    CH_W         = 2,
  parameter slot_t DEF_SLOTS_M1 = 8'd31
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [CH_W+1:0]        addr,
  input  logic [SLOT_W-1:0]      wdata,
  input  logic                   load,
  output chan_cfg_t [NCH-1:0]    act_cfg,
  output slot_t                  act_slots_m1,
  output logic                   act_dbl
);
  localparam logic [1:0] F_TX = 2'd0, F_RX = 2'd1, F_CTL = 2'd2, F_GLB = 2'd3;

  logic [1:0]          fld;
  logic [CH_W-1:0]     sel;
  chan_cfg_t [NCH-1:0] shd_cfg;
  slot_t               shd_slots_m1;
  logic                shd_dbl;

  assign fld = addr[CH_W+1:CH_W];
  assign sel = addr[CH_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_cfg      <= '0;
      act_cfg      <= '0;
      shd_slots_m1 <= DEF_SLOTS_M1;
      act_slots_m1 <= DEF_SLOTS_M1;
      shd_dbl      <= 1'b0;
      act_dbl      <= 1'b0;
    end else begin
      if (we) begin
        if (fld == F_GLB) begin
          if (sel == CH_W'(0)) shd_slots_m1 <= wdata;
          if (sel == CH_W'(1)) shd_dbl      <= wdata[0];
        end else begin
          for (int c = 0; c < NCH; c++) begin
            if (sel == CH_W'(c)) begin
              case (fld)
                F_TX:    shd_cfg[c].tx_slot <= wdata;
                F_RX:    shd_cfg[c].rx_slot <= wdata;
                F_CTL: begin
                  shd_cfg[c].en  <= wdata[SLOT_W-1];
                  shd_cfg[c].ofs <= wdata[OFS_W-1:0];
                end
                default: ;
              endcase
            end
          end
        end
      end
      if (load) begin
        act_cfg      <= shd_cfg;
        act_slots_m1 <= shd_slots_m1;
        act_dbl      <= shd_dbl;
      end
    end
  end

  // R8: active settings move only on a frame sync
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_cfg) && $stable(act_slots_m1) && $stable(act_dbl)));
endmodule

// File: rtl/pcm_tsi_timer.sv
module pcm_tsi_timer
  import pcm_tsi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  slot_t            slots_m1,
  input  logic             dbl,
  output logic [CNT_W-1:0] cnt,
  output logic             synced
);
  logic [CNT_W-1:0] last;
  assign last = frame_last(slots_m1, dbl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      synced <= 1'b0;
    end else if (fsync) begin
      cnt    <= '0;
      synced <= 1'b1;
    end else if (synced) begin
      cnt <= (cnt == last) ? '0 : cnt + CNT_W'(1);
    end
  end

  assert_fsync_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (cnt == '0 && synced));
  assert_no_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
    synced |-> (cnt <= last));
endmodule

// File: rtl/pcm_tsi_chan.sv
module pcm_tsi_chan
  import pcm_tsi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg,
  input  logic [POS_W-1:0] pos,
  input  logic             last_ph,
  input  logic             live,
  input  logic             frame_load,
  input  logic             rx_bit,
  input  logic             load,
  input  logic [SMP_W-1:0] load_val,
  output logic             tx_req,
  output logic             tx_bit,
  output logic             rx_valid,
  output logic [SMP_W-1:0] rx_val
);
  logic [SMP_W-1:0] hold, frame_val, shreg;
  logic [BIT_W-1:0] idx;
  logic             rx_hit, rx_done;

  assign idx     = bit_of(pos, cfg.ofs);
  assign tx_req  = live && cfg.en && slot_hit(pos, cfg.ofs, cfg.tx_slot);
  assign tx_bit  = frame_val[~idx];
  assign rx_hit  = live && cfg.en && last_ph && slot_hit(pos, cfg.ofs, cfg.rx_slot);
  assign rx_done = rx_hit && (idx == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= '0;
      frame_val <= '0;
      shreg     <= '0;
      rx_val    <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (load)       hold      <= load_val;
      if (frame_load) frame_val <= hold;
      if (rx_hit)     shreg     <= {shreg[SMP_W-2:0], rx_bit};
      if (rx_done) begin
        rx_val   <= {shreg[SMP_W-2:0], rx_bit};
        rx_valid <= 1'b1;
      end
    end
  end

  assert_rx_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_frame_byte_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> $stable(frame_val));
endmodule

// File: rtl/pcm_tsi_arb.sv
module pcm_tsi_arb #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] bits,
  output logic           oe,
  output logic           dout
);
  logic [NCH-1:0] grant;

  always_comb begin
    grant = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i] && (grant == '0)) grant[i] = 1'b1;
    end
  end

  assign oe   = |req;
  assign dout = |(grant & bits);

  assert_one_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  for (genvar gi = 1; gi < NCH; gi++) begin : g_prio
    assert_low_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      grant[gi] |-> !(|req[gi-1:0]));
  end
endmodule

// File: rtl/pcm_tsi_quad.sv
module pcm_tsi_quad
  import pcm_tsi_pkg::*;
#(
  parameter int    NCH          = 4,
  parameter slot_t DEF_SLOTS_M1 = 8'd31,
  localparam int   CH_W         = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fsync,
  input  logic                 rx_data,
  output logic                 tx_data,
  output logic                 tx_oe,
  input  logic                 cfg_we,
  input  logic [CH_W+1:0]      cfg_addr,
  input  logic [SLOT_W-1:0]    cfg_wdata,
  input  logic [NCH-1:0]       tx_load,
  input  logic [NCH*SMP_W-1:0] tx_sample,
  output logic [NCH-1:0]       rx_valid,
  output logic [NCH*SMP_W-1:0] rx_sample
);
  chan_cfg_t [NCH-1:0] act_cfg;
  slot_t               act_slots_m1;
  logic                act_dbl;
  logic [CNT_W-1:0]    cnt;
  logic                synced;
  logic [POS_W-1:0]    pos;
  logic                lph;
  logic [NCH-1:0]      req, bits;
  logic                arb_dout;

  pcm_tsi_cfg #(.NCH(NCH), .CH_W(CH_W), .DEF_SLOTS_M1(DEF_SLOTS_M1)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .load(fsync), .act_cfg(act_cfg), .act_slots_m1(act_slots_m1), .act_dbl(act_dbl));

  pcm_tsi_timer u_timer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .slots_m1(act_slots_m1),
    .dbl(act_dbl), .cnt(cnt), .synced(synced));

  assign pos = pos_of(cnt, act_dbl);
  assign lph = last_phase(cnt, act_dbl);

  for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
    pcm_tsi_chan u_ch (
      .clk(clk), .rst_n(rst_n), .cfg(act_cfg[gc]), .pos(pos), .last_ph(lph),
      .live(synced), .frame_load(fsync), .rx_bit(rx_data), .load(tx_load[gc]),
      .load_val(tx_sample[gc*SMP_W +: SMP_W]), .tx_req(req[gc]), .tx_bit(bits[gc]),
      .rx_valid(rx_valid[gc]), .rx_val(rx_sample[gc*SMP_W +: SMP_W]));
  end

  pcm_tsi_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .bits(bits), .oe(tx_oe), .dout(arb_dout));

  assign tx_data = tx_oe ? arb_dout : 1'b0;

  assert_quiet_unsynced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (!tx_oe && rx_valid == '0));
  assert_data_low_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> !tx_data);
endmodule

// File: tb/tb_pcm_tsi_quad.sv
module tb_pcm_tsi_quad;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, rx_data = 1'b0, cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [3:0]  tx_load = '0;
  logic [31:0] tx_sample = '0;
  wire         tx_data, tx_oe;
  wire  [3:0]  rx_valid;
  wire  [31:0] rx_sample;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_tsi_quad dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rx_data(rx_data), .tx_data(tx_data),
    .tx_oe(tx_oe), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_load(tx_load), .tx_sample(tx_sample), .rx_valid(rx_valid), .rx_sample(rx_sample));

  int checks = 0, errors = 0;

  // bench model: pending (p_) and active (a_) settings
  logic [7:0] p_tx[4], p_rx[4], a_tx[4], a_rx[4], hold[4], snap[4];
  logic [2:0] p_off[4], a_off[4];
  logic       p_en[4], a_en[4];
  logic [7:0] p_slm1 = 8'd31, a_slm1 = 8'd31;
  logic       p_dbl = 1'b0, a_dbl = 1'b0;

  logic        rec_oe[256], rec_tx[256], rx_bits[256];
  logic [3:0]  rec_v[256];
  logic [31:0] rec_b[256];

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_wr(input logic [3:0] a, input logic [7:0] d);
    case (a[3:2])
      2'd0: p_tx[a[1:0]] = d;
      2'd1: p_rx[a[1:0]] = d;
      2'd2: begin p_en[a[1:0]] = d[7]; p_off[a[1:0]] = d[2:0]; end
      default: begin
        if (a[1:0] == 2'd0) p_slm1 = d;
        if (a[1:0] == 2'd1) p_dbl  = d[0];
      end
    endcase
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    model_wr(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int c, input logic [7:0] txs, input logic [7:0] rxs, input logic [7:0] ctl);
    wr(4'(c), txs);
    wr(4'(4 + c), rxs);
    wr(4'(8 + c), ctl);
  endtask

  task automatic load(input int c, input logic [7:0] b);
    @(negedge clk);
    tx_load[c] = 1'b1; tx_sample[c*8 +: 8] = b; hold[c] = b;
    @(negedge clk);
    tx_load = '0;
  endtask

  function automatic void exp_tx(input int k, output logic eo, output logic eb);
    int p;
    eo = 1'b0; eb = 1'b0;
    p = a_dbl ? k / 2 : k;
    for (int c = 0; c < 4; c++) begin
      if (!eo && a_en[c] && p >= int'(a_off[c]) && (p - int'(a_off[c])) / 8 == int'(a_tx[c])) begin
        eo = 1'b1;
        eb = snap[c][7 - ((p - int'(a_off[c])) % 8)];
      end
    end
  endfunction

  task automatic run_frame(input bit do_sync, input string ttag, input string rtag,
                           input int mid_k, input logic [3:0] mid_a, input logic [7:0] mid_d,
                           input int ld_ch, input logic [7:0] ld_b, input int seed);
    int L;
    if (do_sync) begin
      fsync = 1'b1;
      for (int c = 0; c < 4; c++) begin
        a_tx[c] = p_tx[c]; a_rx[c] = p_rx[c]; a_off[c] = p_off[c]; a_en[c] = p_en[c];
        snap[c] = hold[c];
      end
      a_slm1 = p_slm1; a_dbl = p_dbl;
    end
    L = ((int'(a_slm1) + 1) * 8) << a_dbl;
    @(posedge clk);
    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      fsync = 1'b0; cfg_we = 1'b0; tx_load = '0;
      rec_oe[k] = tx_oe; rec_tx[k] = tx_data; rec_v[k] = rx_valid; rec_b[k] = rx_sample;
      rx_bits[k] = 1'(((k * 5 + seed) ^ (k >> 1)) & 1);
      rx_data = rx_bits[k];
      if (k == mid_k) begin
        cfg_we = 1'b1; cfg_addr = mid_a; cfg_wdata = mid_d;
        model_wr(mid_a, mid_d);
        if (ld_ch >= 0) begin
          tx_load[ld_ch] = 1'b1; tx_sample[ld_ch*8 +: 8] = ld_b; hold[ld_ch] = ld_b;
        end
      end
    end
    // transmit side, every cycle of the frame
    begin
      int bad = 0, fk = -1, fa = 0, fe = 0;
      for (int k = 0; k < L; k++) begin
        logic eo, eb;
        exp_tx(k, eo, eb);
        if (rec_oe[k] !== eo || (eo && rec_tx[k] !== eb)) begin
          bad++;
          if (fk < 0) begin fk = k; fa = {rec_oe[k], rec_tx[k]}; fe = {eo, eb}; end
        end
      end
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL %s tx {oe,data} at cycle %0d actual=%0h expected=%0h (%0d bad cycles)",
                 ttag, fk, fa, fe, bad);
      end
    end
    // receive side, one check per channel
    for (int c = 0; c < 4; c++) begin
      int kv = -1, base, bad = 0;
      logic [7:0] eb = '0;
      if (a_en[c]) begin
        base = int'(a_off[c]) + 8 * int'(a_rx[c]);
        kv = (a_dbl ? 2 * (base + 7) + 1 : base + 7) + 1;
        if (kv >= L) kv = -1;
        for (int j = 0; j < 8; j++) begin
          int cy = a_dbl ? 2 * (base + j) + 1 : base + j;
          if (cy < L) eb[7 - j] = rx_bits[cy];
        end
      end
      for (int k = 0; k < L; k++) begin
        if (rec_v[k][c] !== (k == kv)) bad++;
      end
      check(rtag, $sformatf("ch%0d rx_valid mis-timed cycles", c), bad, 0);
      if (kv >= 0) check(rtag, $sformatf("ch%0d rx_sample", c), int'(rec_b[kv][c*8 +: 8]), int'(eb));
    end
  endtask

  // R1: quiet before the first frame sync
  task automatic t_reset();
    int bad = 0;
    @(negedge clk);
    check("R1", "tx_oe after reset", int'(tx_oe), 0);
    check("R1", "rx_valid after reset", int'(rx_valid), 0);
    setup(0, 8'd0, 8'd0, 8'h80);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      rx_data = i[0];
      if (tx_oe !== 1'b0 || rx_valid !== 4'b0) bad++;
    end
    check("R1", "activity before sync", bad, 0);
  endtask

  // R3 R4 R6 R10: four channels at distinct slots, one disabled; R2 wrap without sync
  task automatic t_basic();
    wr(4'hC, 8'd7);
    setup(0, 8'd1, 8'd2, 8'h80);
    setup(1, 8'd4, 8'd5, 8'h83);
    setup(2, 8'd6, 8'd0, 8'h81);
    setup(3, 8'd3, 8'd3, 8'h00);
    load(0, 8'hA5); load(1, 8'h3C); load(2, 8'hF0); load(3, 8'h81);
    run_frame(1'b1, "R3/R6/R10", "R4/R6", -1, 4'h0, 8'h0, -1, 8'h0, 3);
    run_frame(1'b0, "R2", "R2/R4", -1, 4'h0, 8'h0, -1, 8'h0, 11);
  endtask

  // R8 R9: a write and a load early in a frame change nothing until the next sync
  task automatic t_midframe();
    run_frame(1'b1, "R8/R9", "R8", 4, 4'h0, 8'd2, 0, 8'h66, 5);
    run_frame(1'b1, "R8/R9", "R8", -1, 4'h0, 8'h0, -1, 8'h0, 7);
  endtask

  // R7: two channels share a transmit slot
  task automatic t_collide();
    wr(4'h8, 8'h00);
    setup(1, 8'd2, 8'd5, 8'h80);
    setup(2, 8'd2, 8'd0, 8'h80);
    load(1, 8'h5A); load(2, 8'hC3);
    run_frame(1'b1, "R7", "R7/R4", -1, 4'h0, 8'h0, -1, 8'h0, 9);
  endtask

  // R5: two clocks per bit
  task automatic t_double();
    setup(3, 8'd3, 8'd6, 8'h85);
    load(3, 8'h96);
    wr(4'hD, 8'h01);
    run_frame(1'b1, "R5", "R5", -1, 4'h0, 8'h0, -1, 8'h0, 13);
  endtask

  // R2: shorter frame wraps at 32 bits
  task automatic t_short();
    wr(4'hD, 8'h00);
    wr(4'hC, 8'd3);
    run_frame(1'b1, "R2", "R2", -1, 4'h0, 8'h0, -1, 8'h0, 17);
    run_frame(1'b0, "R2", "R2", -1, 4'h0, 8'h0, -1, 8'h0, 19);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      p_tx[c] = '0; p_rx[c] = '0; a_tx[c] = '0; a_rx[c] = '0; hold[c] = '0; snap[c] = '0;
      p_off[c] = '0; a_off[c] = '0; p_en[c] = 1'b0; a_en[c] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_midframe();
    t_collide();
    t_double();
    t_short();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule